// File: doc/BRIEF.md
# Serial Controller Register Front End with Threshold Receive Queue

This block is the register side of a simple serial controller. A host reaches seven byte-wide registers through a single-cycle read/write port: mode, control, transmit data, status, receive data, queue control and port. Bytes that arrive from a serialiser (not part of this block) are held in a 16-entry receive queue. A programmable threshold on that queue drives a "receive data full" flag and the receive interrupt. Writing the transmit data register hands one byte to the serialiser as a single-cycle strobe.

Status flags are cleared by writing zero to their bit positions, and writing one leaves them alone. A status read while the transmitter is enabled marks the transmit path idle again, which lets polling software loop on the status register. Reads of the receive data register pop the queue, and the full flag is re-evaluated against the threshold on every pop.

Register index on `bus_addr`: 0 mode, 1 control, 2 transmit data, 3 status, 4 receive data, 5 queue control, 6 port; index 7 reads zero. `bus_rdata` is combinational from the current state. Read side effects and write effects take place at the clock edge that ends the access.

Top module: `uart_regfile`

## Requirements
- R1: After reset the status register reads 0x60, control reads 0x20, mode, port and queue control read 0x00, and both interrupt lines are low.
- R2: A byte on `rx_data` with `rx_valid` is stored only while control bit 4 is 1. When the queue already holds 16 bytes, further bytes are dropped.
- R3: Reading index 4 returns the oldest stored byte and removes it, in arrival order. When the queue is empty the read returns 0x00 and changes nothing.
- R4: Queue control bits 7:6 select the threshold: 0→1, 1→4, 2→8, 3→14 bytes. An accepted byte that leaves the count at or above the threshold sets status bit 1 (receive full), and raises `rx_irq` if control bit 6 is 1.
- R5: A pop that leaves the count below the threshold clears status bit 1.
- R6: Status flags sit at bit 6 (transmit end), bit 5 (transmit empty), bit 4 (break), bit 1 (receive full) and bit 0 (data ready). A status write clears each flag whose bit is written 0 and keeps each flag whose bit is written 1. An accepted byte sets bit 0.
- R7: A status write with bit 1 or bit 0 equal to 0 drops `rx_irq`.
- R8: A control write with bit 5 at 0 sets transmit end. A control write with bit 6 at 0 drops `rx_irq`. Control bit 7 drives `tx_irq`.
- R9: A write to index 2 produces `tx_valid` for exactly one cycle, after the write edge, with that byte on `tx_data`, and clears transmit empty.
- R10: A status read while control bit 5 is 1 returns the flags as they stood, then sets transmit end and transmit empty.
- R11: Writes are masked per register: mode keeps 0x7B, control keeps 0xFA, port keeps 0xF3, queue control keeps 0xFD. The kept bits read back.
- R12: A queue control write with bit 1 set empties the queue, so a following read of index 4 returns 0x00.
- R13: A pulse on `rx_break` sets status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (for side effects) |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break condition seen on the line |
| tx_valid | output | 1 | One-cycle strobe of a byte to send |
| tx_data | output | 8 | Byte to send |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The bench fills the queue past capacity, so a design that overwrote the oldest entry or wrapped its count would return the wrong seventeenth read. It steps every threshold code one byte below and at its level; an off-by-one compare shows up as a flag set one byte early or late. It checks that write-one bits survive a status write, which catches a design that cleared on one or cleared everything. A random mix of pushes, pops, threshold changes and status reads is compared against a reference model, which exposes broken tail wrap and a full flag that is not re-evaluated on a pop.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    typedef enum logic [2:0] {
        REG_MODE = 3'd0,
        REG_CTRL = 3'd1,
        REG_TXD  = 3'd2,
        REG_STAT = 3'd3,
        REG_RXD  = 3'd4,
        REG_FCTL = 3'd5,
        REG_PORT = 3'd6
    } reg_sel_e;

    localparam logic [7:0] MODE_MASK = 8'h7B;
    localparam logic [7:0] CTRL_MASK = 8'hFA;
    localparam logic [7:0] PORT_MASK = 8'hF3;
    localparam logic [7:0] FCTL_MASK = 8'hFD;
    localparam logic [7:0] CTRL_RST  = 8'h20;

    localparam int CB_TXIE = 7;
    localparam int CB_RXIE = 6;
    localparam int CB_TXEN = 5;
    localparam int CB_RXEN = 4;
    localparam int QB_FLUSH = 1;

    function automatic int unsigned trig_level(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_rf_rxq.sv
module uart_rf_rxq #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    input  logic          flush,
    output logic [DW-1:0] dout,
    output logic          push_ok,
    output logic          pop_ok,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nx
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] head, tail;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ok = push && (count != CW'(DEPTH)) && !flush;
    assign pop_ok  = pop && (count != '0) && !flush;
    assign dout    = (count != '0) ? mem[tail] : '0;

    always_comb begin
        if (flush)
            count_nx = '0;
        else
            count_nx = count + CW'(push_ok) - CW'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            count <= count_nx;
            if (flush) begin
                head <= '0;
                tail <= '0;
            end else begin
                if (push_ok) head <= bump(head);
                if (pop_ok)  tail <= bump(tail);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[head] <= din;
    end
endmodule

// File: rtl/uart_rf_flags.sv
module uart_rf_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sr_wr,
    input  logic [4:0] keep,
    input  logic       set_tend,
    input  logic       clr_tde,
    input  logic       set_txidle,
    input  logic       brk,
    input  logic       set_dr,
    input  logic       set_rdf,
    input  logic       clr_rdf,
    input  logic       rxie,
    input  logic       rxie_off,
    output logic [4:0] fl,
    output logic       rx_irq
);
    // fl = {tend, tde, brk, rdf, dr}
    logic [4:0] fl_nx;
    logic       irq_nx;

    always_comb begin
        fl_nx = fl;
        if (sr_wr)      fl_nx = fl_nx & keep;
        if (clr_tde)    fl_nx[3] = 1'b0;
        if (set_tend)   fl_nx[4] = 1'b1;
        if (set_txidle) fl_nx[4:3] = 2'b11;
        if (brk)        fl_nx[2] = 1'b1;
        if (set_dr)     fl_nx[0] = 1'b1;
        if (clr_rdf)    fl_nx[1] = 1'b0;
        if (set_rdf)    fl_nx[1] = 1'b1;
    end

    always_comb begin
        irq_nx = rx_irq;
        if (sr_wr && !(keep[1] && keep[0])) irq_nx = 1'b0;
        if (rxie_off)                       irq_nx = 1'b0;
        if (set_rdf && rxie)                irq_nx = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl     <= 5'b11000;
            rx_irq <= 1'b0;
        end else begin
            fl     <= fl_nx;
            rx_irq <= irq_nx;
        end
    end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_rf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_break,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       rx_irq,
    output logic       tx_irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0] mode_q, ctrl_q, port_q, fctl_q, txd_q;
    logic       tx_valid_q;
    logic [7:0] head_byte, sr_byte;
    logic [4:0] fl;
    logic [CW-1:0] rx_count, cnt_nx, trig;
    logic       push_ok, pop_ok;
    reg_sel_e   sel;

    assign sel = reg_sel_e'(bus_addr);

    logic wr_mode, wr_ctrl, wr_txd, wr_stat, wr_fctl, wr_port;
    logic rd_stat, rd_rxd, flush;

    assign wr_mode = bus_wr && (sel == REG_MODE);
    assign wr_ctrl = bus_wr && (sel == REG_CTRL);
    assign wr_txd  = bus_wr && (sel == REG_TXD);
    assign wr_stat = bus_wr && (sel == REG_STAT);
    assign wr_fctl = bus_wr && (sel == REG_FCTL);
    assign wr_port = bus_wr && (sel == REG_PORT);
    assign rd_stat = bus_rd && (sel == REG_STAT);
    assign rd_rxd  = bus_rd && (sel == REG_RXD);
    assign flush   = wr_fctl && bus_wdata[QB_FLUSH];

    assign trig = CW'(trig_level(fctl_q[7:6]));

    uart_rf_rxq #(.DEPTH(DEPTH), .DW(8)) u_rxq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rx_valid && ctrl_q[CB_RXEN]),
        .din      (rx_data),
        .pop      (rd_rxd),
        .flush    (flush),
        .dout     (head_byte),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .count    (rx_count),
        .count_nx (cnt_nx)
    );

    uart_rf_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .sr_wr      (wr_stat),
        .keep       ({bus_wdata[6], bus_wdata[5], bus_wdata[4], bus_wdata[1], bus_wdata[0]}),
        .set_tend   (wr_ctrl && !bus_wdata[CB_TXEN]),
        .clr_tde    (wr_txd),
        .set_txidle (rd_stat && ctrl_q[CB_TXEN]),
        .brk        (rx_break),
        .set_dr     (push_ok),
        .set_rdf    (push_ok && (cnt_nx >= trig)),
        .clr_rdf    (pop_ok && !push_ok && (cnt_nx < trig)),
        .rxie       (ctrl_q[CB_RXIE]),
        .rxie_off   (wr_ctrl && !bus_wdata[CB_RXIE]),
        .fl         (fl),
        .rx_irq     (rx_irq)
    );

    assign sr_byte = {1'b0, fl[4], fl[3], fl[2], 2'b00, fl[1], fl[0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= '0;
            ctrl_q     <= CTRL_RST;
            port_q     <= '0;
            fctl_q     <= '0;
            txd_q      <= '0;
            tx_valid_q <= 1'b0;
        end else begin
            tx_valid_q <= wr_txd;
            if (wr_mode) mode_q <= bus_wdata & MODE_MASK;
            if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;
            if (wr_port) port_q <= bus_wdata & PORT_MASK;
            if (wr_fctl) fctl_q <= bus_wdata & FCTL_MASK;
            if (wr_txd)  txd_q  <= bus_wdata;
        end
    end

    always_comb begin
        case (sel)
            REG_MODE: bus_rdata = mode_q;
            REG_CTRL: bus_rdata = ctrl_q;
            REG_TXD:  bus_rdata = txd_q;
            REG_STAT: bus_rdata = sr_byte;
            REG_RXD:  bus_rdata = head_byte;
            REG_FCTL: bus_rdata = fctl_q;
            REG_PORT: bus_rdata = port_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign tx_valid = tx_valid_q;
    assign tx_data  = txd_q;
    assign tx_irq   = ctrl_q[CB_TXIE];
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [2:0]    bus_addr,
    input logic [7:0]    bus_wdata,
    input logic          rx_valid,
    input logic          rx_break,
    input logic          tx_valid,
    input logic [7:0]    tx_data,
    input logic          rx_irq,
    input logic [CW-1:0] count,
    input logic [7:0]    status
);
    logic txd_w, ctl_w, flush_w, pop_r;
    assign txd_w   = bus_wr && (bus_addr == 3'd2);
    assign ctl_w   = bus_wr && (bus_addr == 3'd1);
    assign flush_w = bus_wr && (bus_addr == 3'd5) && bus_wdata[1];
    assign pop_r   = bus_rd && (bus_addr == 3'd4);

    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R2
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH) && rx_valid && !pop_r && !flush_w) |=> count == CW'(DEPTH)); // R2
    AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        txd_w |=> (tx_valid && tx_data == $past(bus_wdata))); // R9
    AST_TX_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        !txd_w |=> !tx_valid); // R9
    AST_TDE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        txd_w |=> !status[5]); // R9
    AST_RXIRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_w && !bus_wdata[6] && !rx_valid) |=> !rx_irq); // R8
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush_w |=> count == '0); // R12
    AST_BRK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_break |=> status[4]); // R13
endmodule

bind uart_regfile uart_regfile_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rx_valid  (rx_valid),
    .rx_break  (rx_break),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .rx_irq    (rx_irq),
    .count     (rx_count),
    .status    (sr_byte)
);

// File: tb/tb_uart_regfile.sv
module tb_uart_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_valid = 1'b0, rx_break = 1'b0;
    logic [7:0] rx_data = '0;
    logic       tx_valid, rx_irq, tx_irq;
    logic [7:0] tx_data;

    int nchk = 0, nerr = 0;
    bit done = 0;

    // reference model
    logic [7:0] q[$];
    int   trig = 1;
    bit   m_tend = 1, m_tde = 1, m_brk = 0, m_rdf = 0, m_dr = 0, m_irq = 0;
    logic [7:0] m_ctrl = 8'h20;

    uart_regfile dut (.*);

    always #10 clk = ~clk;

    function automatic int lvl(input logic [1:0] c);
        return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
    endfunction

    function automatic logic [7:0] exp_sr();
        return {1'b0, m_tend, m_tde, m_brk, 2'b00, m_rdf, m_dr};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1 bus_wr = 0;
        case (a)
            3'd1: begin
                m_ctrl = d & 8'hFA;
                if (!d[5]) m_tend = 1;
                if (!d[6]) m_irq = 0;
            end
            3'd2: m_tde = 0;
            3'd3: begin
                if (!d[6]) m_tend = 0;
                if (!d[5]) m_tde = 0;
                if (!d[4]) m_brk = 0;
                if (!d[1]) m_rdf = 0;
                if (!d[0]) m_dr = 0;
                if (!d[1] || !d[0]) m_irq = 0;
            end
            3'd5: begin
                trig = lvl(d[7:6]);
                if (d[1]) q.delete();
            end
            default: ;
        endcase
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        bus_rd = 1; bus_addr = a;
        #1 v = bus_rdata;
        @(posedge clk); #1 bus_rd = 0;
    endtask

    task automatic push(input logic [7:0] b);
        rx_valid = 1; rx_data = b;
        @(posedge clk); #1 rx_valid = 0;
        if (m_ctrl[4] && q.size() < 16) begin
            q.push_back(b);
            m_dr = 1;
            if (q.size() >= trig) begin
                m_rdf = 1;
                if (m_ctrl[6]) m_irq = 1;
            end
        end
    endtask

    task automatic pop_chk(input string req);
        logic [7:0] v, e;
        rd(3'd4, v);
        e = 8'h00;
        if (q.size() > 0) begin
            e = q.pop_front();
            if (q.size() < trig) m_rdf = 0;
        end
        chk(req, v, e);
    endtask

    task automatic sr_chk(input string req);
        logic [7:0] v;
        rd(3'd3, v);
        chk(req, v, exp_sr());
        if (m_ctrl[5]) begin m_tend = 1; m_tde = 1; end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;

        // R1 reset state
        sr_chk("R1 status");
        rd(3'd1, v); chk("R1 ctrl", v, 8'h20);
        rd(3'd0, v); chk("R1 mode", v, 8'h00);
        rd(3'd6, v); chk("R1 port", v, 8'h00);
        rd(3'd5, v); chk("R1 fctl", v, 8'h00);
        chk("R1 irqs", {6'd0, rx_irq, tx_irq}, 8'h00);

        // R11 masks, R8 tx_irq
        wr(3'd0, 8'hFF); rd(3'd0, v); chk("R11 mode", v, 8'h7B);
        wr(3'd6, 8'hFF); rd(3'd6, v); chk("R11 port", v, 8'hF3);
        wr(3'd1, 8'hFF); rd(3'd1, v); chk("R11 ctrl", v, 8'hFA);
        chk("R8 tx_irq high", {7'd0, tx_irq}, 8'h01);
        wr(3'd3, 8'h00); sr_chk("R6 all cleared");
        wr(3'd1, 8'h00);
        chk("R8 tx_irq low", {7'd0, tx_irq}, 8'h00);
        sr_chk("R8 tend set by txen=0");

        // R2 receive disabled, R3 empty read
        push(8'h3C);
        pop_chk("R3 empty read after disabled push");
        sr_chk("R2 no data ready");

        // R13 break, R6 keep-ones
        rx_break = 1; @(posedge clk); #1 rx_break = 0; m_brk = 1;
        sr_chk("R13 break set");
        wr(3'd3, 8'hEF); sr_chk("R6 only break cleared");

        // R9 transmit, R10 status read sets idle
        wr(3'd1, 8'h20);
        wr(3'd2, 8'hA5);
        chk("R9 tx_valid", {7'd0, tx_valid}, 8'h01);
        chk("R9 tx_data", tx_data, 8'hA5);
        @(posedge clk); #1;
        chk("R9 one-shot", {7'd0, tx_valid}, 8'h00);
        sr_chk("R9 tde cleared");
        sr_chk("R10 tde tend set after read");

        // R4 R5 R2 fill and drain with threshold 4
        wr(3'd1, 8'h70);
        wr(3'd5, 8'h40);
        for (int i = 0; i < 3; i++) push(8'h10 + 8'(i));
        sr_chk("R4 below threshold");
        chk("R4 no irq yet", {7'd0, rx_irq}, 8'h00);
        push(8'h13);
        sr_chk("R4 at threshold");
        chk("R4 irq raised", {7'd0, rx_irq}, 8'h01);
        for (int i = 4; i < 17; i++) push(8'h10 + 8'(i));
        for (int i = 0; i < 13; i++) pop_chk("R2 order");
        sr_chk("R5 count 3 below 4");
        for (int i = 0; i < 3; i++) pop_chk("R2 order tail");
        pop_chk("R2 seventeenth dropped");
        wr(3'd1, 8'h30);
        chk("R8 rx_irq dropped by ctrl", {7'd0, rx_irq}, 8'h00);
        wr(3'd1, 8'h70);

        // R4 each threshold code
        for (int c = 0; c < 4; c++) begin
            wr(3'd5, 8'(c << 6) | 8'h02);
            wr(3'd3, 8'hFC);
            for (int k = 1; k < lvl(2'(c)); k++) push(8'(k));
            sr_chk($sformatf("R4 code %0d one short", c));
            push(8'hEE);
            sr_chk($sformatf("R4 code %0d reached", c));
        end
        chk("R4 irq before clear", {7'd0, rx_irq}, 8'h01);
        wr(3'd3, 8'hFE);
        chk("R7 irq dropped by dr clear", {7'd0, rx_irq}, 8'h00);

        // R12 flush
        wr(3'd5, 8'h02);
        pop_chk("R12 empty after flush");
        rd(3'd5, v); chk("R12 flush bit not kept", v, 8'h00);

        // random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            op = $urandom % 8;
            if (op < 3) push(8'($urandom));
            else if (op < 6) pop_chk("R3 random pop");
            else if (op == 6) sr_chk("R5 random status");
            else wr(3'd5, 8'($urandom % 4) << 6);
            chk("R4 random irq", {7'd0, rx_irq}, {7'd0, m_irq});
        end

        done = 1;
        finish_run();
    end
endmodule